// File: doc/BRIEF.md
# Four-Phase Handshake Stage Controller

This block is the clocked sequencer for one self-timed pipeline stage. Three lines come in from the outside: an upstream request, a completion signal from the stage's datapath, and a downstream acknowledge. It drives three lines out: a start command to the datapath, a downstream request and an upstream acknowledge. Every line follows return-to-zero signalling. Each transfer therefore has a rising half and a falling half. In the rising half the datapath computes. In the falling half it is put back to its idle condition. Both halves are sequenced strictly between the two handshakes.

The controller samples its inputs through a parameterised chain of synchronising flops. It moves through six waiting states, and in each state it waits, with no limit, for exactly one input to change. Its outputs come straight from flops, so they never glitch. The upstream side keeps its bundled data lines stable while its request is high. The controller raises the downstream request only after the datapath reports completion, so downstream data is never announced while it is still changing. Any input pattern that cannot occur in the current state under a correct partner sets a sticky error flag. Only reset clears that flag.

Top module: `hs4_stage_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first edge after release, `dp_start`, `dn_req`, `up_ack` and `order_err` are all low, and the controller waits for `up_req`.
- R2: Each input passes through `SYNC_STAGES` flops. An output reacts to an input change on the (`SYNC_STAGES`+1)-th rising clock edge after that change.
- R3: The rising half runs in this order. `dp_start` rises after `up_req` is seen high. `dn_req` rises after `dp_done` is seen high. `up_ack` rises after `dn_ack` is seen high. The sampled vector {up_req,dp_done,dn_ack} is 100, 110 and 111 in the cycle before each of these three rises.
- R4: The falling half runs in this order. `dp_start` falls after `up_req` is seen low. `dn_req` falls after `dp_done` is seen low. `up_ack` falls after `dn_ack` is seen low. The sampled vectors before these three falls are 011, 001 and 000.
- R5: Each state waits any number of cycles for its awaited input, with no timeout. While that input does not arrive, all outputs hold their values.
- R6: At most one output changes per clock edge. The output vector {dp_start,dn_req,up_ack} steps through 100, 110, 111, 011, 001, 000 and then returns to idle.
- R7: In each state the sampled input vector is legal only if it equals that state's entry vector or its exit vector. Any other value raises `order_err` on the (`SYNC_STAGES`+1)-th edge after the offending change. An illegal vector never advances the sequence.
- R8: Once `order_err` is high it stays high until reset, even after the inputs become legal again.
- R9: A new transfer may begin as soon as `up_ack` is low. Transfers that follow one another back to back, or with slow partners, produce the same output sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| up_req | input | 1 | Request from the upstream stage |
| dp_done | input | 1 | Completion from the datapath |
| dn_ack | input | 1 | Acknowledge from the downstream stage |
| dp_start | output | 1 | Start command to the datapath |
| dn_req | output | 1 | Request to the downstream stage |
| up_ack | output | 1 | Acknowledge to the upstream stage |
| order_err | output | 1 | Sticky flag for an out-of-order input |

## Verification
The bench builds the controller with `SYNC_STAGES` = 2. With that depth the reaction latency is three edges, which is long enough to tell one edge early from one edge late. The bench plays both partners. It runs transfers with zero, small and 25-cycle response delays, so both the back-to-back path and indefinite waiting are exercised. It injects two illegal patterns, one while idle and one in the middle of a transfer, to show the flag's latency, its stickiness and that the sequence does not advance.

// File: rtl/hs4_pkg.sv
package hs4_pkg;

  localparam int NUM_LINES = 3;

  // Input vector order: {up_req, dp_done, dn_ack}
  typedef logic [NUM_LINES-1:0] hs_lines_t;
  // Output vector order: {dp_start, dn_req, up_ack}
  typedef logic [NUM_LINES-1:0] hs_drive_t;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RUN     = 3'd1,
    ST_PUSH    = 3'd2,
    ST_GRANT   = 3'd3,
    ST_CLEAR   = 3'd4,
    ST_RELEASE = 3'd5
  } hs_state_t;

  // Input vector seen while a state waits.
  function automatic hs_lines_t entry_vec(hs_state_t s);
    unique case (s)
      ST_IDLE:    return 3'b000;
      ST_RUN:     return 3'b100;
      ST_PUSH:    return 3'b110;
      ST_GRANT:   return 3'b111;
      ST_CLEAR:   return 3'b011;
      ST_RELEASE: return 3'b001;
      default:    return 3'b000;
    endcase
  endfunction

  // Input vector that lets a state advance.
  function automatic hs_lines_t exit_vec(hs_state_t s);
    unique case (s)
      ST_IDLE:    return 3'b100;
      ST_RUN:     return 3'b110;
      ST_PUSH:    return 3'b111;
      ST_GRANT:   return 3'b011;
      ST_CLEAR:   return 3'b001;
      ST_RELEASE: return 3'b000;
      default:    return 3'b100;
    endcase
  endfunction

  function automatic hs_state_t succ_of(hs_state_t s);
    unique case (s)
      ST_IDLE:    return ST_RUN;
      ST_RUN:     return ST_PUSH;
      ST_PUSH:    return ST_GRANT;
      ST_GRANT:   return ST_CLEAR;
      ST_CLEAR:   return ST_RELEASE;
      default:    return ST_IDLE;
    endcase
  endfunction

  function automatic hs_drive_t drive_of(hs_state_t s);
    unique case (s)
      ST_RUN:     return 3'b100;
      ST_PUSH:    return 3'b110;
      ST_GRANT:   return 3'b111;
      ST_CLEAR:   return 3'b011;
      ST_RELEASE: return 3'b001;
      default:    return 3'b000;
    endcase
  endfunction

  function automatic logic is_legal(hs_state_t s, hs_lines_t v);
    return (v == entry_vec(s)) || (v == exit_vec(s));
  endfunction

endpackage

// File: rtl/hs4_sync.sv
module hs4_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign d_out = d_in;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '0;
        end else begin
          chain[0] <= d_in;
          for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
      end
      assign d_out = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/hs4_seq.sv
module hs4_seq
  import hs4_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  hs_lines_t lines,
  output hs_state_t state,
  output hs_drive_t drive,
  output logic      step_evt
);

  hs_state_t state_nx;

  assign step_evt = (lines == exit_vec(state));
  assign state_nx = step_evt ? succ_of(state) : state;

  // Outputs registered alongside the state so they never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      drive <= '0;
    end else begin
      state <= state_nx;
      drive <= drive_of(state_nx);
    end
  end

endmodule

// File: rtl/hs4_guard.sv
module hs4_guard
  import hs4_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  hs_state_t state,
  input  hs_lines_t lines,
  output logic      bad_evt,
  output logic      err_flag
);

  assign bad_evt = !is_legal(state, lines);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_flag <= 1'b0;
    else if (bad_evt) err_flag <= 1'b1;
  end

endmodule

// File: rtl/hs4_stage_ctrl.sv
module hs4_stage_ctrl
  import hs4_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_req,
  input  logic dp_done,
  input  logic dn_ack,
  output logic dp_start,
  output logic dn_req,
  output logic up_ack,
  output logic order_err
);

  hs_lines_t raw_lines;
  hs_lines_t in_sync;
  hs_state_t cur_state;
  hs_drive_t drive;
  logic      step_evt;
  logic      bad_evt;

  assign raw_lines = {up_req, dp_done, dn_ack};

  hs4_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (raw_lines),
    .d_out (in_sync)
  );

  hs4_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .lines    (in_sync),
    .state    (cur_state),
    .drive    (drive),
    .step_evt (step_evt)
  );

  hs4_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (cur_state),
    .lines    (in_sync),
    .bad_evt  (bad_evt),
    .err_flag (order_err)
  );

  assign {dp_start, dn_req, up_ack} = drive;

endmodule

// File: rtl/hs4_stage_ctrl_chk.sv
module hs4_stage_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dp_start,
  input logic       dn_req,
  input logic       up_ack,
  input logic       order_err,
  input logic [2:0] in_sync,
  input logic       step_evt,
  input logic       bad_evt
);

  logic [2:0] outs;
  assign outs = {dp_start, dn_req, up_ack};

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (outs == 3'b000) && !order_err);

  p_rise_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dp_start) |-> $past(in_sync) == 3'b100);
  p_rise_dnreq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_req) |-> $past(in_sync) == 3'b110);
  p_rise_upack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_ack) |-> $past(in_sync) == 3'b111);

  p_fall_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dp_start) |-> $past(in_sync) == 3'b011);
  p_fall_dnreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn_req) |-> $past(in_sync) == 3'b001);
  p_fall_upack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up_ack) |-> $past(in_sync) == 3'b000);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !step_evt |=> $stable(outs));

  p_one_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(outs ^ $past(outs)) <= 1);

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> order_err);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    order_err |=> order_err);

endmodule

bind hs4_stage_ctrl hs4_stage_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dp_start  (dp_start),
  .dn_req    (dn_req),
  .up_ack    (up_ack),
  .order_err (order_err),
  .in_sync   (in_sync),
  .step_evt  (step_evt),
  .bad_evt   (bad_evt)
);

// File: tb/test_hs4_stage_ctrl.sv
module test_hs4_stage_ctrl;

  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_req = 1'b0;
  logic dp_done = 1'b0;
  logic dn_ack = 1'b0;
  logic dp_start, dn_req, up_ack, order_err;

  int n_checks = 0;
  int n_errors = 0;
  logic [2:0] exp_q[$];
  logic [2:0] last_outs = 3'b000;

  always #2 clk = ~clk;  // 250 MHz

  hs4_stage_ctrl #(.SYNC_STAGES(SYNC)) i_hs4_stage_ctrl (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .dp_done(dp_done),
    .dn_ack(dn_ack), .dp_start(dp_start), .dn_req(dn_req),
    .up_ack(up_ack), .order_err(order_err)
  );

  function automatic logic [2:0] outs();
    return {dp_start, dn_req, up_ack};
  endfunction

  task automatic check(bit ok, string req, string what, logic [3:0] act, logic [3:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor: every output change must match the next expected item (R6).
  always @(negedge clk) begin
    if (!rst_n) begin
      last_outs = outs();
    end else if (outs() != last_outs) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_errors++;
        $display("FAIL R6 unexpected output change: actual=%b expected=none", outs());
      end else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        if (outs() != e) begin
          n_errors++;
          $display("FAIL %s output step: actual=%b expected=%b",
                   (e[2] && !(e == 3'b011)) ? "R3" : "R4", outs(), e);
        end
      end
      last_outs = outs();
    end
  end

  task automatic wait_out(int idx, logic val);
    while (outs()[idx] !== val) @(negedge clk);
  endtask

  // Driver: plays both partners for one transfer and queues the expected steps.
  task automatic transfer(int hold, bit chk_lat);
    exp_q.push_back(3'b100); exp_q.push_back(3'b110); exp_q.push_back(3'b111);
    exp_q.push_back(3'b011); exp_q.push_back(3'b001); exp_q.push_back(3'b000);
    up_req = 1'b1;
    if (chk_lat) begin
      for (int i = 0; i < SYNC; i++) @(negedge clk);
      check(dp_start == 1'b0, "R2", "start one edge early", {3'b0, dp_start}, 4'd0);
      @(negedge clk);
      check(dp_start == 1'b1, "R2", "start latency", {3'b0, dp_start}, 4'd1);
    end
    wait_out(2, 1'b1);
    repeat (hold) @(negedge clk);
    if (hold > 0) check(outs() == 3'b100, "R5", "wait for done", {1'b0, outs()}, 4'b0100);
    dp_done = 1'b1;
    wait_out(1, 1'b1);
    repeat (hold) @(negedge clk);
    dn_ack = 1'b1;
    wait_out(0, 1'b1);
    repeat (hold) @(negedge clk);
    up_req = 1'b0;
    wait_out(2, 1'b0);
    repeat (hold) @(negedge clk);
    if (hold > 0) check(outs() == 3'b011, "R5", "wait for done low", {1'b0, outs()}, 4'b0011);
    dp_done = 1'b0;
    wait_out(1, 1'b0);
    repeat (hold) @(negedge clk);
    dn_ack = 1'b0;
    wait_out(0, 1'b0);
    @(negedge clk);
    check(exp_q.size() == 0, "R9", "transfer complete", 4'(exp_q.size()), 4'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    up_req = 1'b0; dp_done = 1'b0; dn_ack = 1'b0;
    exp_q.delete();
    repeat (SYNC + 2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    check(outs() == 3'b000, "R1", "outputs in reset", {1'b0, outs()}, 4'd0);
    check(order_err == 1'b0, "R1", "flag in reset", {3'b0, order_err}, 4'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(outs() == 3'b000 && !order_err, "R1", "after release", {order_err, outs()}, 4'd0);

    transfer(0, 1'b1);    // R2 latency, R3/R4 order
    transfer(25, 1'b0);   // R5 slow partners
    transfer(0, 1'b0);    // R9 back to back
    transfer(3, 1'b1);
    check(order_err == 1'b0, "R7", "no flag on legal traffic", {3'b0, order_err}, 4'd0);

    // Illegal pattern while idle: dn_ack rises without dn_req.
    dn_ack = 1'b1;
    for (int i = 0; i < SYNC; i++) @(negedge clk);
    check(order_err == 1'b0, "R7", "flag one edge early", {3'b0, order_err}, 4'd0);
    @(negedge clk);
    check(order_err == 1'b1, "R7", "flag latency", {3'b0, order_err}, 4'd1);
    dn_ack = 1'b0;
    repeat (10) @(negedge clk);
    check(order_err == 1'b1, "R8", "flag sticky", {3'b0, order_err}, 4'd1);
    check(outs() == 3'b000, "R7", "no advance on illegal input", {1'b0, outs()}, 4'd0);

    do_reset();
    check(order_err == 1'b0, "R8", "flag cleared by reset", {3'b0, order_err}, 4'd0);
    transfer(2, 1'b0);

    // Illegal pattern mid-transfer: up_req drops while dn_req is high.
    exp_q.push_back(3'b100); exp_q.push_back(3'b110);
    up_req = 1'b1;
    wait_out(2, 1'b1);
    dp_done = 1'b1;
    wait_out(1, 1'b1);
    repeat (4) @(negedge clk);
    up_req = 1'b0;
    repeat (SYNC + 1) @(negedge clk);
    check(order_err == 1'b1, "R7", "early request drop flagged", {3'b0, order_err}, 4'd1);
    repeat (6) @(negedge clk);
    check(outs() == 3'b110, "R7", "hold on illegal vector", {1'b0, outs()}, 4'b0110);
    check(exp_q.size() == 0, "R6", "steps before violation", 4'(exp_q.size()), 4'd0);
    do_reset();
    check(outs() == 3'b000 && !order_err, "R1", "second reset", {order_err, outs()}, 4'd0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL R5 watchdog: actual=hung expected=finished");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule